// File: doc/BRIEF.md
# Dual-Width Virtual Machine Arithmetic Unit

This block is the arithmetic execution stage of a small register-based virtual machine. Each accepted operation carries a 4-bit operation code, the current destination register value, a second operand, and a flag choosing 64-bit or 32-bit arithmetic. The second operand is either a register value or a 32-bit immediate taken from the instruction word. The unit returns the value to write back, a write-enable, and a flag for division by zero. All three are registered and appear one clock after the request.

In 32-bit mode the unit looks only at the low halves of its operands and clears the upper half of the result. The exception is byte-order conversion, whose width comes from the immediate. Division and remainder are unsigned. Neither of them traps: a zero divisor gives a defined result and raises the flag. Decoding, the register file and any further exception handling sit outside this block.

Top module: `vm_alu`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 multiply (low bits of product), 4 OR, 5 AND, 10 XOR and 11 move (result is the second operand). All arithmetic wraps modulo 2^64 in 64-bit mode and modulo 2^32 in 32-bit mode.
- R2: When the source bit `use_reg` is 1, the second operand is `reg_val`. When it is 0, the second operand is `imm`, sign-extended to 64 bits in 64-bit mode and zero-extended in 32-bit mode.
- R3: When `wide` is 0, every operation except code 13 computes on bits 31:0 of both operands only, and result bits 63:32 are zero.
- R4: Code 6 shifts left, code 7 shifts right logically and code 12 shifts right arithmetically, keeping the sign bit of the active width. The shift amount is the second operand masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode.
- R5: Code 3 is unsigned divide and code 9 is unsigned remainder, both within the active width.
- R6: If the active-width divisor is zero, code 3 returns 0. Code 9 returns the destination in 64-bit mode and the zero-extended low half of the destination in 32-bit mode. In both cases `div_zero` is 1 in the result cycle; otherwise it is 0.
- R7: Code 8 returns the two's-complement negation of the destination and ignores the second operand.
- R8: Code 13 converts byte order. `imm` equal to 16 selects 2 bytes, 32 selects 4 bytes, and any other value selects 8 bytes. With `use_reg` 0 the low bytes of the destination pass unchanged; with `use_reg` 1 their order is reversed. Bytes above the chosen width are zero, and `wide` has no effect.
- R9: A request with `in_valid` high produces `out_valid`, `result`, `wr_en` and `div_zero` at the next rising clock edge. `wr_en` is high for codes 0 to 13. For codes 14 and 15, `wr_en` is low and `result` is zero. Without a request, `wr_en` and `div_zero` are low and `result` holds its last value.
- R10: Synchronous active-high `rst` clears `out_valid`, `result`, `wr_en` and `div_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_reg | input | 1 | Source bit: 1 = register operand, 0 = immediate |
| dst_val | input | 64 | Destination register value |
| reg_val | input | 64 | Source register value |
| imm | input | 32 | Instruction immediate |
| out_valid | output | 1 | Result cycle marker |
| result | output | 64 | Value to write back |
| wr_en | output | 1 | Write-back enable |
| div_zero | output | 1 | Divisor was zero for divide or remainder |

## Verification
Every result of this unit is due exactly one rising edge after the request that caused it. There is one register stage between the inputs and `result`, `wr_en`, `div_zero` and `out_valid`. The bench changes inputs on the falling edge, lets one rising edge pass, and compares at the following falling edge, so the sampled value is always the one produced by that single edge. The hold behaviour is checked one further idle cycle later, when `wr_en` must be low and `result` unchanged.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_ARSH = 4'hC,
    OP_END  = 4'hD
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_32 = 2'd1,
    SW_64 = 2'd2
  } swap_width_e;

  function automatic logic op_legal(input logic [3:0] code);
    return code <= 4'hD;
  endfunction

endpackage

// File: rtl/vm_alu_opsel.sv
module vm_alu_opsel #(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic            wide,
  input  logic            use_reg,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] reg_val,
  input  logic [ILEN-1:0] imm,
  output logic [XLEN-1:0] a_eff,
  output logic [XLEN-1:0] b_eff
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] b_raw;

  always_comb begin
    if (wide) imm_ext = {{(XLEN-ILEN){imm[ILEN-1]}}, imm};
    else      imm_ext = {{(XLEN-ILEN){1'b0}}, imm};
    b_raw = use_reg ? reg_val : imm_ext;
    if (wide) begin
      a_eff = dst_val;
      b_eff = b_raw;
    end else begin
      a_eff = {{HLEN{1'b0}}, dst_val[HLEN-1:0]};
      b_eff = {{HLEN{1'b0}}, b_raw[HLEN-1:0]};
    end
  end
endmodule

// File: rtl/vm_alu_shift.sv
module vm_alu_shift
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            wide,
  input  shift_kind_e     kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int HLEN = XLEN / 2;
  localparam int SW   = $clog2(XLEN);
  localparam int SH   = $clog2(HLEN);

  logic [SW-1:0]   amt_w;
  logic [SH-1:0]   amt_h;
  logic [HLEN-1:0] a_lo;
  logic [HLEN-1:0] y_lo;
  logic [XLEN-1:0] y_w;

  assign amt_w = b[SW-1:0];
  assign amt_h = b[SH-1:0];
  assign a_lo  = a[HLEN-1:0];

  always_comb begin
    unique case (kind)
      SH_LEFT: begin
        y_w  = a << amt_w;
        y_lo = a_lo << amt_h;
      end
      SH_RLOG: begin
        y_w  = a >> amt_w;
        y_lo = a_lo >> amt_h;
      end
      default: begin
        y_w  = $unsigned($signed(a) >>> amt_w);
        y_lo = $unsigned($signed(a_lo) >>> amt_h);
      end
    endcase
    y = wide ? y_w : {{HLEN{1'b0}}, y_lo};
  end
endmodule

// File: rtl/vm_alu_divmod.sv
module vm_alu_divmod #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem,
  output logic            zero
);
  // Operands arrive already narrowed to the active width, so a
  // single full-width divider serves both modes.
  always_comb begin
    zero = (b == '0);
    if (zero) begin
      quo = '0;
      rem = a;
    end else begin
      quo = a / b;
      rem = a % b;
    end
  end
endmodule

// File: rtl/vm_alu_bswap.sv
module vm_alu_bswap
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  swap_width_e     width,
  input  logic            reverse,
  output logic [XLEN-1:0] y
);
  localparam int NB  = XLEN / 8;
  localparam int NB4 = 4;
  localparam int NB2 = 2;

  logic [XLEN-1:0] rev64;
  logic [31:0]     rev32;
  logic [15:0]     rev16;

  for (genvar i = 0; i < NB; i++) begin : g_rev64
    assign rev64[i*8 +: 8] = a[(NB-1-i)*8 +: 8];
  end
  for (genvar i = 0; i < NB4; i++) begin : g_rev32
    assign rev32[i*8 +: 8] = a[(NB4-1-i)*8 +: 8];
  end
  for (genvar i = 0; i < NB2; i++) begin : g_rev16
    assign rev16[i*8 +: 8] = a[(NB2-1-i)*8 +: 8];
  end

  always_comb begin
    unique case (width)
      SW_16:   y = {{(XLEN-16){1'b0}}, reverse ? rev16 : a[15:0]};
      SW_32:   y = {{(XLEN-32){1'b0}}, reverse ? rev32 : a[31:0]};
      default: y = reverse ? rev64 : a;
    endcase
  end
endmodule

// File: rtl/vm_alu.sv
module vm_alu
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic            wide,
  input  logic            use_reg,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] reg_val,
  input  logic [ILEN-1:0] imm,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            div_zero
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] a_eff, b_eff;
  logic [XLEN-1:0] sh_y, quo, rem, sw_y;
  logic            dz_raw;
  shift_kind_e     sh_kind;
  swap_width_e     sw_width;
  logic [XLEN-1:0] core_y, next_y;
  logic            next_dz;

  vm_alu_opsel #(.XLEN(XLEN), .ILEN(ILEN)) u_opsel (
    .wide(wide), .use_reg(use_reg), .dst_val(dst_val),
    .reg_val(reg_val), .imm(imm), .a_eff(a_eff), .b_eff(b_eff)
  );

  always_comb begin
    unique case (op)
      OP_LSH:  sh_kind = SH_LEFT;
      OP_RSH:  sh_kind = SH_RLOG;
      default: sh_kind = SH_RARI;
    endcase
  end

  vm_alu_shift #(.XLEN(XLEN)) u_shift (
    .wide(wide), .kind(sh_kind), .a(a_eff), .b(b_eff), .y(sh_y)
  );

  vm_alu_divmod #(.XLEN(XLEN)) u_div (
    .a(a_eff), .b(b_eff), .quo(quo), .rem(rem), .zero(dz_raw)
  );

  always_comb begin
    if (imm == ILEN'(16))      sw_width = SW_16;
    else if (imm == ILEN'(32)) sw_width = SW_32;
    else                       sw_width = SW_64;
  end

  vm_alu_bswap #(.XLEN(XLEN)) u_swap (
    .a(dst_val), .width(sw_width), .reverse(use_reg), .y(sw_y)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  core_y = a_eff + b_eff;
      OP_SUB:  core_y = a_eff - b_eff;
      OP_MUL:  core_y = a_eff * b_eff;
      OP_DIV:  core_y = quo;
      OP_OR:   core_y = a_eff | b_eff;
      OP_AND:  core_y = a_eff & b_eff;
      OP_LSH, OP_RSH, OP_ARSH: core_y = sh_y;
      OP_NEG:  core_y = '0 - a_eff;
      OP_MOD:  core_y = rem;
      OP_XOR:  core_y = a_eff ^ b_eff;
      OP_MOV:  core_y = b_eff;
      OP_END:  core_y = sw_y;
      default: core_y = '0;
    endcase
    if (!wide && op != OP_END) next_y = {{HLEN{1'b0}}, core_y[HLEN-1:0]};
    else                       next_y = core_y;
    next_dz = dz_raw && (op == OP_DIV || op == OP_MOD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      div_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && op_legal(op);
      div_zero  <= in_valid && next_dz;
      if (in_valid) result <= next_y;
    end
  end
endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk #(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [3:0]      op,
  input logic            wide,
  input logic            use_reg,
  input logic [XLEN-1:0] dst_val,
  input logic [XLEN-1:0] reg_val,
  input logic [ILEN-1:0] imm,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            wr_en,
  input logic            div_zero
);
  localparam int HLEN = XLEN / 2;

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && !div_zero && $stable(result)));

  // R3
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide && op != 4'hD) |=> (result[XLEN-1:HLEN] == '0));

  // R6
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide && use_reg && op == 4'h3 && reg_val == '0)
      |=> (div_zero && result == '0));

  // R7
  neg_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide && op == 4'h8) |=> (result == '0 - $past(dst_val)));

  // R2
  mov_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide && use_reg && op == 4'hB) |=> (result == $past(reg_val)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && !div_zero && result == '0));

  // R9
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);
endmodule

bind vm_alu vm_alu_chk #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
  .use_reg(use_reg), .dst_val(dst_val), .reg_val(reg_val), .imm(imm),
  .out_valid(out_valid), .result(result), .wr_en(wr_en), .div_zero(div_zero)
);

// File: tb/vm_alu_tb_top.sv
module vm_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic        wide;
  logic        use_reg;
  logic [63:0] dst_val;
  logic [63:0] reg_val;
  logic [31:0] imm;
  logic        out_valid;
  logic [63:0] result;
  logic        wr_en;
  logic        div_zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
    .use_reg(use_reg), .dst_val(dst_val), .reg_val(reg_val), .imm(imm),
    .out_valid(out_valid), .result(result), .wr_en(wr_en), .div_zero(div_zero)
  );

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h3:             return "R5";
      4'h6, 4'h7, 4'hC: return "R4";
      4'h8:             return "R7";
      4'h9:             return "R5";
      4'hD:             return "R8";
      4'hE, 4'hF:       return "R9";
      default:          return "R1";
    endcase
  endfunction

  function automatic void model(
    input logic [3:0] c, input logic w, input logic s,
    input logic [63:0] d, input logic [63:0] rv, input logic [31:0] im,
    output logic [63:0] r, output logic dz, output logic we);
    logic [63:0] bsrc, x, y;
    int nb;
    bsrc = s ? rv : (w ? {{32{im[31]}}, im} : {32'h0, im});
    x = w ? d : {32'h0, d[31:0]};
    y = w ? bsrc : {32'h0, bsrc[31:0]};
    dz = 1'b0;
    we = (c < 4'hE);
    case (c)
      4'h0: r = x + y;
      4'h1: r = x - y;
      4'h2: r = x * y;
      4'h3: begin dz = (y == 0); r = dz ? 64'h0 : x / y; end
      4'h4: r = x | y;
      4'h5: r = x & y;
      4'h6: r = w ? x << y[5:0] : x << y[4:0];
      4'h7: r = w ? x >> y[5:0] : x >> y[4:0];
      4'h8: r = -x;
      4'h9: begin dz = (y == 0); r = dz ? x : x % y; end
      4'hA: r = x ^ y;
      4'hB: r = y;
      4'hC: begin
        if (w) r = $unsigned($signed(x) >>> y[5:0]);
        else   r = {32'h0, $unsigned($signed(x[31:0]) >>> y[4:0])};
      end
      4'hD: begin
        nb = (im == 16) ? 2 : (im == 32) ? 4 : 8;
        r = 64'h0;
        for (int k = 0; k < nb; k++)
          r[k*8 +: 8] = s ? d[(nb-1-k)*8 +: 8] : d[k*8 +: 8];
      end
      default: r = 64'h0;
    endcase
    if (!w && c != 4'hD) r = {32'h0, r[31:0]};
  endfunction

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] c, input logic w,
                        input logic s, input logic [63:0] d,
                        input logic [63:0] rv, input logic [31:0] im);
    logic [63:0] er;
    logic edz, ewe;
    model(c, w, s, d, rv, im, er, edz, ewe);
    @(negedge clk);
    op = c; wide = w; use_reg = s; dst_val = d; reg_val = rv; imm = im;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64(req, "result", result, er);
    check64("R6", "div_zero", {63'h0, div_zero}, {63'h0, edz});
    check64("R9", "wr_en", {63'h0, wr_en}, {63'h0, ewe});
    check64("R9", "out_valid", {63'h0, out_valid}, 64'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; in_valid = 1'b0; op = 4'h0; wide = 1'b1; use_reg = 1'b0;
    dst_val = 64'h0; reg_val = 64'h0; imm = 32'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check64("R10", "result", result, 64'h0);
    check64("R10", "flags", {61'h0, out_valid, wr_en, div_zero}, 64'h0);
    rst = 1'b0;

    // R1
    run_op("R1", 4'h0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 32'h0);
    run_op("R1", 4'h2, 1, 1, 64'h1_0000_0001, 64'h3, 32'h0);
    // R2: immediate sign extension vs zero extension
    run_op("R2", 4'hB, 1, 0, 64'h0, 64'h0, 32'h8000_0001);
    run_op("R2", 4'hB, 0, 0, 64'h0, 64'h0, 32'h8000_0001);
    run_op("R2", 4'h0, 1, 0, 64'h10, 64'h0, 32'hFFFF_FFFF);
    // R3: narrow wrap and upper clear
    run_op("R3", 4'h0, 0, 1, 64'hAAAA_AAAA_FFFF_FFFF, 64'h1, 32'h0);
    run_op("R3", 4'h1, 0, 1, 64'h0, 64'h1, 32'h0);
    // R4: shift masking and arithmetic sign
    run_op("R4", 4'h6, 1, 1, 64'h1, 64'h41, 32'h0);
    run_op("R4", 4'h6, 0, 1, 64'h1, 64'h21, 32'h0);
    run_op("R4", 4'hC, 1, 0, 64'h8000_0000_0000_0000, 64'h0, 32'd63);
    run_op("R4", 4'hC, 0, 0, 64'h0000_0001_8000_0000, 64'h0, 32'd4);
    run_op("R4", 4'h7, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'h0, 32'd4);
    // R5: unsigned divide
    run_op("R5", 4'h3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h2, 32'h0);
    run_op("R5", 4'h9, 0, 1, 64'h5_0000_0007, 64'h3, 32'h0);
    // R6: zero divisor
    run_op("R6", 4'h3, 1, 1, 64'h1234, 64'h0, 32'h0);
    run_op("R6", 4'h9, 1, 1, 64'hDEAD_BEEF_0000_1234, 64'h0, 32'h0);
    run_op("R6", 4'h9, 0, 1, 64'hDEAD_BEEF_0000_1234, 64'h7_0000_0000, 32'h0);
    // R7: negate ignores second operand
    run_op("R7", 4'h8, 1, 1, 64'h5, 64'hFFFF, 32'h0);
    run_op("R7", 4'h8, 0, 0, 64'h5, 64'h0, 32'h1234);
    // R8: byte order widths
    run_op("R8", 4'hD, 1, 1, 64'h0102_0304_0506_0708, 64'h0, 32'd16);
    run_op("R8", 4'hD, 0, 1, 64'h0102_0304_0506_0708, 64'h0, 32'd32);
    run_op("R8", 4'hD, 0, 1, 64'h0102_0304_0506_0708, 64'h0, 32'd64);
    run_op("R8", 4'hD, 1, 0, 64'h0102_0304_0506_0708, 64'h0, 32'd16);
    // R9: illegal codes and hold
    run_op("R9", 4'hE, 1, 1, 64'h77, 64'h1, 32'h0);
    run_op("R1", 4'hA, 1, 1, 64'hF0F0, 64'h0FF0, 32'h0);
    held = result;
    @(negedge clk);
    check64("R9", "hold result", result, held);
    check64("R9", "idle wr_en", {63'h0, wr_en}, 64'h0);

    for (int n = 0; n < 600; n++) begin
      logic [3:0]  c;
      logic [63:0] rv;
      logic [31:0] im;
      c  = 4'($urandom_range(0, 15));
      rv = ($urandom_range(0, 7) == 0) ? 64'h0 : {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: im = 32'd16;
        1: im = 32'd32;
        default: im = $urandom;
      endcase
      run_op(tag_of(c), c, 1'($urandom), 1'($urandom), {$urandom, $urandom}, rv, im);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule